// File: doc/BRIEF.md
# Elevator Floor Controller

This block steers a single car serving up to eight floors. A landing call or a request from the in-car panel supplies a 3-bit floor code. The code is captured into a request register, but only while no earlier call is still being served. A position counter tracks the floor the car is on. It steps once for each rising edge of a car-position sensor, in the direction the controller is currently commanding. Comparing the held request with the tracked floor gives the three direction outputs: move up, move down, or stopped with the door open.

When a held call has been reached, a door timer runs for a fixed number of clock cycles, and the direction outputs stay low for that whole time. When the timer expires, a one-cycle close pulse is issued and the held call is released, so the next strobe can be taken. The tracked floor is also shown as a decimal digit on seven active-high segment lines. The sensor input is asynchronous and is brought into the clock domain before its edge is used.

Top module: `liftCtrl`

## Requirements
- R1: After reset, the floor count and the held request code are both 0, no call is held, `stopOpen` is 1, and `upOut`, `downOut` and `closeOut` are 0.
- R2: When no call is held and `hallStrobe` or `panelStrobe` is high at a clock edge, the matching code is captured and a call becomes held. If both strobes are high, `hallCode` wins. The directions that follow from the new code appear in the cycle after that edge.
- R3: While a call is held, from the capture edge until the edge that raises `closeOut`, both strobes are ignored and the held code does not change.
- R4: `stopOpen` is 1 exactly when the held code equals the floor count. `upOut` is 1 when the held code is greater and `downOut` when it is smaller, except during the door interval of R8. `upOut` and `downOut` are never high together.
- R5: `floorSensor` passes through two synchronizer flops. A rising edge seen there changes the floor count on the third clock edge after the input rises. A high level of any length gives exactly one step.
- R6: A sensor step adds one to the floor count while `upOut` is 1 and subtracts one while `downOut` is 1. Otherwise the count holds. The count never moves beyond 0 or 7.
- R7: If a call is held and the held code equals the floor count, the door interval starts at the next edge and lasts DOOR_CYCLES (default 16) cycles. After it, `closeOut` is high for exactly one cycle, and the held call is released at that same edge.
- R8: During the door interval, `upOut` and `downOut` are 0 and sensor edges do not change the floor count.
- R9: `segOut` bit 0 is segment a and bit 6 is segment g, active high. Floors 0 to 7 show 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D and 0x07.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| floorSensor | input | 1 | Car-position pulse, asynchronous |
| hallCode | input | 3 | Floor code of a landing call |
| hallStrobe | input | 1 | Landing call valid |
| panelCode | input | 3 | Floor code from the car panel |
| panelStrobe | input | 1 | Car panel request valid |
| upOut | output | 1 | Command car upward |
| downOut | output | 1 | Command car downward |
| stopOpen | output | 1 | Car at requested floor, door open |
| closeOut | output | 1 | One-cycle door close pulse |
| segOut | output | 7 | Floor digit segments, bit 0 is a |

## Verification
A wrong floor count appears on `segOut` in the same cycle the count changes. It also flips the direction outputs whenever the count crosses the held code, so a miscounted sensor edge is visible within one clock. A wrongly held code or call flag shows up later, as a direction toward the wrong floor or as a door interval and close pulse in the wrong cycle. For that reason every output is compared on every clock against a behavioural model, with no tolerance in timing.

// File: rtl/lift_pkg.sv
package lift_pkg;

  // Strobes from the control module to the datapath
  typedef struct packed {
    logic incFloor;   // step the floor count up
    logic decFloor;   // step the floor count down
    logic loadReq;    // capture a new request code
  } liftStrobe_t;

  // Active-high segment pattern, bit 0 = a ... bit 6 = g
  function automatic logic [6:0] segPattern(input logic [3:0] digit);
    logic [6:0] pat;
    case (digit)
      4'd0:    pat = 7'h3F;
      4'd1:    pat = 7'h06;
      4'd2:    pat = 7'h5B;
      4'd3:    pat = 7'h4F;
      4'd4:    pat = 7'h66;
      4'd5:    pat = 7'h6D;
      4'd6:    pat = 7'h7D;
      4'd7:    pat = 7'h07;
      4'd8:    pat = 7'h7F;
      4'd9:    pat = 7'h6F;
      default: pat = 7'h00;
    endcase
    return pat;
  endfunction

endpackage

// File: rtl/lift_datapath.sv
module lift_datapath
  import lift_pkg::*;
#(
  parameter int FLOOR_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               floorSensor,
  input  logic [FLOOR_W-1:0] hallCode,
  input  logic               hallStrobe,
  input  logic [FLOOR_W-1:0] panelCode,
  input  liftStrobe_t        strobe,
  output logic               sensorRise,
  output logic               reqAbove,
  output logic               reqBelow,
  output logic               reqMatch,
  output logic [FLOOR_W-1:0] floorCnt,
  output logic [FLOOR_W-1:0] reqCode,
  output logic [6:0]         segOut
);

  localparam logic [FLOOR_W-1:0] TOP_FLOOR = {FLOOR_W{1'b1}};
  localparam logic [FLOOR_W-1:0] BOT_FLOOR = '0;

  // Synchronizer chain plus one extra stage for edge detection
  logic [SYNC_STAGES:0] syncSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncSh <= '0;
    else       syncSh <= {syncSh[SYNC_STAGES-1:0], floorSensor};
  end

  assign sensorRise = syncSh[SYNC_STAGES-1] & ~syncSh[SYNC_STAGES];

  // Floor position counter, saturating at both ends
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      floorCnt <= '0;
    end else if (strobe.incFloor && floorCnt != TOP_FLOOR) begin
      floorCnt <= floorCnt + 1'b1;
    end else if (strobe.decFloor && floorCnt != BOT_FLOOR) begin
      floorCnt <= floorCnt - 1'b1;
    end
  end

  // Request register, landing call has priority
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              reqCode <= '0;
    else if (strobe.loadReq) reqCode <= hallStrobe ? hallCode : panelCode;
  end

  // Magnitude comparator
  assign reqMatch = (reqCode == floorCnt);
  assign reqAbove = (reqCode >  floorCnt);
  assign reqBelow = (reqCode <  floorCnt);

  // Floor digit decoder
  generate
    if (FLOOR_W <= 4) begin : g_seg
      always_comb segOut = segPattern(4'(floorCnt));
    end else begin : g_segWide
      always_comb segOut = (floorCnt < 10) ? segPattern(floorCnt[3:0]) : 7'h00;
    end
  endgenerate

endmodule

// File: rtl/lift_control.sv
module lift_control
  import lift_pkg::*;
#(
  parameter int DOOR_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sensorRise,
  input  logic        reqAbove,
  input  logic        reqBelow,
  input  logic        reqMatch,
  input  logic        hallStrobe,
  input  logic        panelStrobe,
  output liftStrobe_t strobe,
  output logic        upOut,
  output logic        downOut,
  output logic        closeOut,
  output logic        callHeld,
  output logic        doorRun
);

  localparam int TMR_W = (DOOR_CYCLES > 1) ? $clog2(DOOR_CYCLES) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(DOOR_CYCLES - 1);

  logic [TMR_W-1:0] doorCnt;
  logic             doorDone;
  logic             anyStrobe;
  logic             doorStart;

  assign anyStrobe = hallStrobe | panelStrobe;
  assign doorDone  = doorRun && (doorCnt == '0);
  assign doorStart = callHeld && reqMatch && !doorRun;

  // Call flag: set on accepted strobe, cleared when the door closes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      callHeld <= 1'b0;
    else if (doorDone)              callHeld <= 1'b0;
    else if (!callHeld && anyStrobe) callHeld <= 1'b1;
  end

  // Door down-counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doorRun <= 1'b0;
      doorCnt <= '0;
    end else if (doorStart) begin
      doorRun <= 1'b1;
      doorCnt <= TMR_LOAD;
    end else if (doorRun) begin
      if (doorDone) doorRun <= 1'b0;
      else          doorCnt <= doorCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) closeOut <= 1'b0;
    else       closeOut <= doorDone;
  end

  // Direction outputs, blocked while the door is open
  assign upOut   = reqAbove & ~doorRun;
  assign downOut = reqBelow & ~doorRun;

  always_comb begin
    strobe          = '0;
    strobe.loadReq  = !callHeld && anyStrobe;
    strobe.incFloor = sensorRise && upOut;
    strobe.decFloor = sensorRise && downOut;
  end

endmodule

// File: rtl/liftCtrl.sv
module liftCtrl
  import lift_pkg::*;
#(
  parameter int FLOOR_W     = 3,
  parameter int SYNC_STAGES = 2,
  parameter int DOOR_CYCLES = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               floorSensor,
  input  logic [FLOOR_W-1:0] hallCode,
  input  logic               hallStrobe,
  input  logic [FLOOR_W-1:0] panelCode,
  input  logic               panelStrobe,
  output logic               upOut,
  output logic               downOut,
  output logic               stopOpen,
  output logic               closeOut,
  output logic [6:0]         segOut
);

  liftStrobe_t        strobe;
  logic               sensorRise;
  logic               reqAbove;
  logic               reqBelow;
  logic               reqMatch;
  logic [FLOOR_W-1:0] floorNow;
  logic [FLOOR_W-1:0] reqNow;
  logic               callHeld;
  logic               doorRun;

  lift_datapath #(
    .FLOOR_W    (FLOOR_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .floorSensor(floorSensor),
    .hallCode   (hallCode),
    .hallStrobe (hallStrobe),
    .panelCode  (panelCode),
    .strobe     (strobe),
    .sensorRise (sensorRise),
    .reqAbove   (reqAbove),
    .reqBelow   (reqBelow),
    .reqMatch   (reqMatch),
    .floorCnt   (floorNow),
    .reqCode    (reqNow),
    .segOut     (segOut)
  );

  lift_control #(
    .DOOR_CYCLES(DOOR_CYCLES)
  ) u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .sensorRise (sensorRise),
    .reqAbove   (reqAbove),
    .reqBelow   (reqBelow),
    .reqMatch   (reqMatch),
    .hallStrobe (hallStrobe),
    .panelStrobe(panelStrobe),
    .strobe     (strobe),
    .upOut      (upOut),
    .downOut    (downOut),
    .closeOut   (closeOut),
    .callHeld   (callHeld),
    .doorRun    (doorRun)
  );

  assign stopOpen = reqMatch;

endmodule

// File: rtl/liftCtrlChecker.sv
module liftCtrlChecker #(
  parameter int FLOOR_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               upOut,
  input logic               downOut,
  input logic               stopOpen,
  input logic               closeOut,
  input logic [FLOOR_W-1:0] floorNow,
  input logic [FLOOR_W-1:0] reqNow,
  input logic               callHeld,
  input logic               doorRun
);

  assert_dir_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(upOut && downOut));

  assert_stop_no_move_R4: assert property (@(posedge clk) disable iff (!rstN)
    stopOpen |-> !(upOut || downOut));

  assert_close_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    closeOut |=> !closeOut);

  assert_close_releases_R7: assert property (@(posedge clk) disable iff (!rstN)
    closeOut |-> !callHeld);

  assert_req_held_R3: assert property (@(posedge clk) disable iff (!rstN)
    callHeld |=> $stable(reqNow));

  assert_floor_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (floorNow != $past(floorNow)) |->
      ((floorNow == FLOOR_W'($past(floorNow) + 1'b1)) ||
       (floorNow == FLOOR_W'($past(floorNow) - 1'b1))));

  assert_door_holds_floor_R8: assert property (@(posedge clk) disable iff (!rstN)
    doorRun |=> $stable(floorNow));

endmodule

bind liftCtrl liftCtrlChecker #(.FLOOR_W(FLOOR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .upOut   (upOut),
  .downOut (downOut),
  .stopOpen(stopOpen),
  .closeOut(closeOut),
  .floorNow(floorNow),
  .reqNow  (reqNow),
  .callHeld(callHeld),
  .doorRun (doorRun)
);

// File: tb/liftCtrl_test.sv
module liftCtrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int DOOR       = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       floorSensor = 1'b0;
  logic [2:0] hallCode = '0;
  logic       hallStrobe = 1'b0;
  logic [2:0] panelCode = '0;
  logic       panelStrobe = 1'b0;
  logic       upOut, downOut, stopOpen, closeOut;
  logic [6:0] segOut;

  liftCtrl #(.DOOR_CYCLES(DOOR)) uut (
    .clk(clk), .rstN(rstN), .floorSensor(floorSensor),
    .hallCode(hallCode), .hallStrobe(hallStrobe),
    .panelCode(panelCode), .panelStrobe(panelStrobe),
    .upOut(upOut), .downOut(downOut), .stopOpen(stopOpen),
    .closeOut(closeOut), .segOut(segOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  function automatic logic [6:0] digitSegs(input int f);
    logic [6:0] t [8] = '{7'h3F, 7'h06, 7'h5B, 7'h4F, 7'h66, 7'h6D, 7'h7D, 7'h07};
    return t[f];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  int  mS1 = 0, mS2 = 0, mS3 = 0;
  int  mFloor = 0, mReq = 0, mHeld = 0, mRun = 0, mCnt = 0, mClose = 0;

  function automatic int mUp();   return (mReq > mFloor && !mRun) ? 1 : 0; endfunction
  function automatic int mDown(); return (mReq < mFloor && !mRun) ? 1 : 0; endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mS1 = 0; mS2 = 0; mS3 = 0;
      mFloor = 0; mReq = 0; mHeld = 0; mRun = 0; mCnt = 0; mClose = 0;
    end else begin
      int rise, up, dn, done, strobeIn;
      int nFloor, nReq, nHeld, nRun, nCnt;
      rise = (mS2 && !mS3) ? 1 : 0;
      up = mUp(); dn = mDown();
      done = (mRun && mCnt == 0) ? 1 : 0;
      strobeIn = (hallStrobe || panelStrobe) ? 1 : 0;
      nFloor = mFloor;
      if (rise && up && mFloor < 7) nFloor = mFloor + 1;
      else if (rise && dn && mFloor > 0) nFloor = mFloor - 1;
      nReq = mReq;
      nHeld = mHeld;
      if (done) nHeld = 0;
      else if (!mHeld && strobeIn) nHeld = 1;
      if (!mHeld && strobeIn) nReq = hallStrobe ? int'(hallCode) : int'(panelCode);
      nRun = mRun; nCnt = mCnt;
      if (mHeld && mReq == mFloor && !mRun) begin nRun = 1; nCnt = DOOR - 1; end
      else if (mRun) begin
        if (done) nRun = 0; else nCnt = mCnt - 1;
      end
      mClose = done;
      mS3 = mS2; mS2 = mS1; mS1 = int'(floorSensor);
      mFloor = nFloor; mReq = nReq; mHeld = nHeld; mRun = nRun; mCnt = nCnt;
    end
  end

  // Every-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      check(int'(upOut) == mUp(), "R4", "upOut", int'(upOut), mUp());
      check(int'(downOut) == mDown(), "R8", "downOut", int'(downOut), mDown());
      check(int'(stopOpen) == ((mReq == mFloor) ? 1 : 0), "R4", "stopOpen",
            int'(stopOpen), (mReq == mFloor) ? 1 : 0);
      check(int'(closeOut) == mClose, "R7", "closeOut", int'(closeOut), mClose);
      check(segOut == digitSegs(mFloor), "R6", "segOut", int'(segOut),
            int'(digitSegs(mFloor)));
    end
  end

  task automatic callHall(input int code);
    @(posedge clk); #1; hallCode = 3'(code); hallStrobe = 1'b1;
    @(posedge clk); #1; hallStrobe = 1'b0;
  endtask

  task automatic callPanel(input int code);
    @(posedge clk); #1; panelCode = 3'(code); panelStrobe = 1'b1;
    @(posedge clk); #1; panelStrobe = 1'b0;
  endtask

  task automatic callBoth(input int h, input int p);
    @(posedge clk); #1; hallCode = 3'(h); panelCode = 3'(p);
    hallStrobe = 1'b1; panelStrobe = 1'b1;
    @(posedge clk); #1; hallStrobe = 1'b0; panelStrobe = 1'b0;
  endtask

  task automatic sensorPulse(input int width);
    @(posedge clk); #1; floorSensor = 1'b1;
    repeat (width) @(posedge clk);
    #1; floorSensor = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic waitClose(input string req);
    int n = 0;
    while (n < 200) begin
      @(negedge clk);
      if (closeOut) break;
      n++;
    end
    check(n < 200, req, "close pulse seen", n, 0);
    @(posedge clk);
  endtask

  task automatic scenario();
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(stopOpen == 1'b1, "R1", "reset stopOpen", int'(stopOpen), 1);
    check(!upOut && !downOut && !closeOut, "R1", "reset directions",
          int'({upOut, downOut, closeOut}), 0);
    check(segOut == 7'h3F, "R9", "reset segments", int'(segOut), 'h3F);

    // R2 landing call upward, R3 panel strobe while held is ignored
    callHall(3);
    @(negedge clk);
    check(upOut == 1'b1, "R2", "up after call 3", int'(upOut), 1);
    callPanel(5);
    repeat (3) sensorPulse(2);
    @(negedge clk);
    check(stopOpen == 1'b1, "R3", "stopped at 3 not 5", int'(stopOpen), 1);
    check(segOut == 7'h4F, "R9", "floor 3 digit", int'(segOut), 'h4F);
    // R8 sensor edge during door interval leaves floor alone
    sensorPulse(2);
    check(segOut == 7'h4F, "R8", "floor held with door open", int'(segOut), 'h4F);
    waitClose("R7");

    // R2 both strobes: landing call wins -> move down
    callBoth(1, 6);
    @(negedge clk);
    check(downOut == 1'b1, "R2", "hall priority down", int'(downOut), 1);
    repeat (2) sensorPulse(2);
    waitClose("R7");
    @(negedge clk);
    check(segOut == 7'h06, "R9", "floor 1 digit", int'(segOut), 'h06);

    // R6 sensor edge while idle has no effect
    sensorPulse(2);
    @(negedge clk);
    check(segOut == 7'h06, "R6", "idle sensor hold", int'(segOut), 'h06);

    // R5 long sensor level counts once
    callPanel(7);
    sensorPulse(10);
    @(negedge clk);
    check(segOut == 7'h5B, "R5", "single step for long pulse", int'(segOut), 'h5B);
    repeat (5) sensorPulse(1);
    waitClose("R7");
    @(negedge clk);
    check(segOut == 7'h07, "R9", "floor 7 digit", int'(segOut), 'h07);

    // R7 call to the current floor opens the door at once
    callHall(7);
    waitClose("R7");

    // Full descent, then an extra pulse at floor 0
    callPanel(0);
    repeat (8) sensorPulse(2);
    waitClose("R7");
    sensorPulse(2);
    @(negedge clk);
    check(segOut == 7'h3F, "R6", "floor 0 after descent", int'(segOut), 'h3F);
    repeat (5) @(posedge clk);
  endtask

  initial begin
    fork
      scenario();
      begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WD", "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule